// File: doc/BRIEF.md
# Shadowed-Match PWM Generator

A counter-based pulse-width modulator with seven compare values. Compare value 0 sets the period, and compares 1 to 6 place the edges of six outputs. Output 1 is always single-edge. Outputs 2 to 6 can each be switched at run time between single-edge generation and double-edge generation. In double-edge mode, the compare of the previous index raises the output and the output's own compare lowers it.

Software writes new compare values into shadow registers. A shadow value reaches the comparator only when its arm bit is set. Even then, the copy happens at the next period boundary, so a waveform never sees a half-updated period. Per-channel control selects flag raising, counter clearing and counter stopping on each compare. With the modulator mode off, the block is a plain timer that keeps the same compare and flag logic.

The register interface is a simple word-wide port. Writes take effect at the clock edge on which `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `pwm_shadow_top`

## Requirements
- R1: After reset every register reads 0, `pwm_out` is 0 and `irq` is low.
- R2: Control register (address 1): bit 0 runs the counter, which then advances by one per cycle, and bit 1 holds the counter at 0. A channel fires in a cycle when the counter runs and equals that channel's active compare value. The counter reads at address 2.
- R3: Address 3 holds three bits per channel c at bits 3c, 3c+1 and 3c+2: flag enable, clear and stop. A firing channel with its clear bit set returns the counter to 0 on the next cycle. A firing channel with its stop bit set freezes the counter and clears control bit 0.
- R4: A firing channel with its flag enable set raises a flag at address 0: channels 0 to 3 use bits 0 to 3 and channels 4 to 6 use bits 8 to 10. `irq` is high while any flag is set. Writing 1 to a flag bit clears it.
- R5: A write to address 8+c lands only in shadow c, which reads back at that address. The active compare value, and with it the waveform, is unchanged while arm bit c is clear.
- R6: Address 5 bit c arms channel c. A period boundary is a channel-0 firing with its clear bit set. On a boundary, every armed channel copies its shadow into its active compare value, and the arm bit then reads 0.
- R7: Single-edge output n (compare Mn, period compare M0) goes high from count 0 and low after count Mn, so it is high for Mn+1 cycles per period. With Mn equal to M0 it stays low, and with Mn above M0 it stays high.
- R8: Address 4 bit n (n = 2..6) selects double-edge mode for output n. The output is high from count M(n-1)+1 through count Mn, which is Mn-M(n-1) cycles, and wraps through the boundary when M(n-1) exceeds Mn. Equal values keep it low.
- R9: Address 4 bits 9 to 14 enable outputs 1 to 6, and a disabled output stays low.
- R10: Control bit 3 selects modulator mode, and with it clear all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | High while any flag is set |
| pwm_out | output | 6 | Modulated outputs 1 to 6 (bit 0 is output 1) |

## Verification
A write is visible at the first falling edge after the rising edge that takes it. The counter value and the flags follow one edge after the counter equals a compare value. An output changes on the edge after its compare fires, so an output is high while the count runs from the raising value plus one up to the lowering value. Shadow transfers need one boundary, so each duty measurement first waits three full periods and then counts high samples over exactly one period. All sampling happens at falling edges, half a cycle clear of every register update.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int FLAG_W = 11;

   localparam logic [ADDR_W-1:0] A_FLAGS = 4'd0;
   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
   localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
   localparam logic [ADDR_W-1:0] A_MCTL  = 4'd3;
   localparam logic [ADDR_W-1:0] A_OCTL  = 4'd4;
   localparam logic [ADDR_W-1:0] A_ARM   = 4'd5;
   localparam int                A_CMP0  = 8;

   localparam int CTRL_RUN = 0;
   localparam int CTRL_CLR = 1;
   localparam int CTRL_PWM = 3;
   localparam int ENA_BASE = 9;

   // flag bit of a channel: low group at 0..3, high group shifted by four
   function automatic int flag_pos(input int ch);
      return (ch < 4) ? ch : ch + 4;
   endfunction
endpackage

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
   parameter int CNT_W     = 16,
   parameter int NUM_MATCH = 7
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_MATCH-1:0]              wr_sel,
   input  logic [CNT_W-1:0]                  wr_val,
   input  logic                              arm_wr,
   input  logic [NUM_MATCH-1:0]              arm_bits,
   input  logic                              boundary,
   output logic [NUM_MATCH-1:0][CNT_W-1:0]   shadow,
   output logic [NUM_MATCH-1:0][CNT_W-1:0]   active,
   output logic [NUM_MATCH-1:0]              armed
);
   for (genvar g = 0; g < NUM_MATCH; g++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow[g] <= '0;
            active[g] <= '0;
            armed[g]  <= 1'b0;
         end else begin
            if (wr_sel[g]) shadow[g] <= wr_val;
            if (boundary && armed[g]) active[g] <= shadow[g];
            if (arm_wr && arm_bits[g]) armed[g] <= 1'b1;
            else if (boundary)         armed[g] <= 1'b0;
         end
      end

      // R6
      copy_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (boundary && armed[g]) |=> (active[g] == $past(shadow[g])));
      // R5
      hold_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!armed[g]) |=> $stable(active[g]));
      // R6
      arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (boundary && !(arm_wr && arm_bits[g])) |=> !armed[g]);
   end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CNT_W     = 16,
   parameter int NUM_MATCH = 7
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            run,
   input  logic                            clr,
   input  logic [NUM_MATCH-1:0][CNT_W-1:0] active,
   input  logic [NUM_MATCH-1:0]            mc_rst,
   input  logic [NUM_MATCH-1:0]            mc_stop,
   output logic [CNT_W-1:0]                cnt,
   output logic [NUM_MATCH-1:0]            hit,
   output logic                            boundary,
   output logic                            stop_evt
);
   logic wrap;

   for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
      assign hit[g] = run && !clr && (cnt == active[g]);
   end

   assign wrap     = |(hit & mc_rst);
   assign stop_evt = |(hit & mc_stop);
   assign boundary = hit[0] & mc_rst[0];

   always_ff @(posedge clk) begin
      if (!rst_n || clr)   cnt <= '0;
      else if (run) begin
         if (wrap)          cnt <= '0;
         else if (!stop_evt) cnt <= cnt + 1'b1;
      end
   end

   // R2
   clr_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R2
   free_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && hit == '0) |=> (cnt == $past(cnt) + 1'b1));
   // R3
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
   parameter int NUM_OUT   = 6,
   parameter int NUM_MATCH = NUM_OUT + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwm_on,
   input  logic [NUM_MATCH-1:0] hit,
   input  logic                 boundary,
   input  logic [NUM_OUT-1:0]   dbl,
   input  logic [NUM_OUT-1:0]   ena,
   output logic [NUM_OUT-1:0]   pwm_out
);
   logic [NUM_OUT-1:0] lvl;
   logic [NUM_OUT-1:0] rise;

   for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
      if (j == 0) begin : g_single_only
         assign rise[j] = boundary;
      end else begin : g_selectable
         assign rise[j] = dbl[j] ? hit[j] : boundary;
      end

      always_ff @(posedge clk) begin
         if (!rst_n || !pwm_on) lvl[j] <= 1'b0;
         else if (hit[j+1])     lvl[j] <= 1'b0;
         else if (rise[j])      lvl[j] <= 1'b1;
      end

      assign pwm_out[j] = lvl[j] & ena[j] & pwm_on;

      // R7
      fall_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit[j+1] |=> !pwm_out[j]);
      // R10
      mode_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pwm_on |=> !lvl[j]);
      // R7
      single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pwm_on && boundary && !hit[j+1] && (j == 0 || !dbl[j])) |=> lvl[j]);
   end
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
   import pwm_shadow_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_OUT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              irq,
   output logic [5:0]        pwm_out
);
   localparam int NUM_MATCH = NUM_OUT + 1;
   localparam int MCTL_W    = 3 * NUM_MATCH;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (NUM_OUT != 6) begin : g_bad_outs
      $error("register layout fixes NUM_OUT at 6");
   end

   logic                            run_q, clr_q, pwm_q;
   logic [MCTL_W-1:0]               mctl_q;
   logic [NUM_OUT-1:0]              dbl_q, ena_q;
   logic [FLAG_W-1:0]               flags_q, flag_set;
   logic [NUM_MATCH-1:0]            mc_int, mc_rst, mc_stop;
   logic [NUM_MATCH-1:0]            wr_sel, hit, armed;
   logic [NUM_MATCH-1:0][CNT_W-1:0] shadow, active;
   logic [CNT_W-1:0]                cnt;
   logic                            boundary, stop_evt, ctrl_wr;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   always_comb begin
      for (int c = 0; c < NUM_MATCH; c++) begin
         mc_int[c]  = mctl_q[3*c];
         mc_rst[c]  = mctl_q[3*c+1];
         mc_stop[c] = mctl_q[3*c+2];
      end
   end

   for (genvar g = 0; g < NUM_MATCH; g++) begin : g_sel
      localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(A_CMP0 + g);
      assign wr_sel[g] = wr_en && (wr_addr == CMP_ADDR);
   end

   always_comb begin
      flag_set = '0;
      for (int c = 0; c < NUM_MATCH; c++)
         flag_set[flag_pos(c)] = hit[c] & mc_int[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         clr_q   <= 1'b0;
         pwm_q   <= 1'b0;
         mctl_q  <= '0;
         dbl_q   <= '0;
         ena_q   <= '0;
         flags_q <= '0;
      end else begin
         if (ctrl_wr) begin
            run_q <= wr_data[CTRL_RUN];
            clr_q <= wr_data[CTRL_CLR];
            pwm_q <= wr_data[CTRL_PWM];
         end else if (stop_evt) begin
            run_q <= 1'b0;
         end
         if (wr_en && wr_addr == A_MCTL) mctl_q <= wr_data[MCTL_W-1:0];
         if (wr_en && wr_addr == A_OCTL) begin
            for (int j = 0; j < NUM_OUT; j++) begin
               dbl_q[j] <= (j == 0) ? 1'b0 : wr_data[j+1];
               ena_q[j] <= wr_data[ENA_BASE+j];
            end
         end
         if (wr_en && wr_addr == A_FLAGS)
            flags_q <= flag_set | (flags_q & ~wr_data[FLAG_W-1:0]);
         else
            flags_q <= flag_set | flags_q;
      end
   end

   assign irq = |flags_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_FLAGS: rd_data[FLAG_W-1:0] = flags_q;
         A_CTRL: begin
            rd_data[CTRL_RUN] = run_q;
            rd_data[CTRL_CLR] = clr_q;
            rd_data[CTRL_PWM] = pwm_q;
         end
         A_COUNT: rd_data[CNT_W-1:0]  = cnt;
         A_MCTL:  rd_data[MCTL_W-1:0] = mctl_q;
         A_OCTL: begin
            for (int j = 0; j < NUM_OUT; j++) begin
               rd_data[j+1]        = dbl_q[j];
               rd_data[ENA_BASE+j] = ena_q[j];
            end
         end
         A_ARM:   rd_data[NUM_MATCH-1:0] = armed;
         default: begin
            for (int c = 0; c < NUM_MATCH; c++)
               if (rd_addr == ADDR_W'(A_CMP0 + c)) rd_data[CNT_W-1:0] = shadow[c];
         end
      endcase
   end

   pwm_cmp_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_val(wr_data[CNT_W-1:0]),
      .arm_wr(wr_en && wr_addr == A_ARM), .arm_bits(wr_data[NUM_MATCH-1:0]),
      .boundary(boundary), .shadow(shadow), .active(active), .armed(armed));

   pwm_counter #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_q), .clr(clr_q), .active(active),
      .mc_rst(mc_rst), .mc_stop(mc_stop), .cnt(cnt), .hit(hit),
      .boundary(boundary), .stop_evt(stop_evt));

   pwm_wave #(.NUM_OUT(NUM_OUT), .NUM_MATCH(NUM_MATCH)) u_wave (
      .clk(clk), .rst_n(rst_n), .pwm_on(pwm_q), .hit(hit), .boundary(boundary),
      .dbl(dbl_q), .ena(ena_q), .pwm_out(pwm_out));

   // R3
   stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !ctrl_wr) |=> !run_q);
   // R4
   flag0_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && mc_int[0]) |=> (flags_q[0] && irq));
   // R4
   flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[7:4] == 4'b0));
endmodule

// File: tb/tb_pwm_shadow_top.sv
`timescale 1ns/1ps
module tb_pwm_shadow_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;
   logic [5:0]  pwm_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pwm_shadow_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq), .pwm_out(pwm_out));

   // period, compare 1, compare 2, double-edge, expected high cycles of output 2
   localparam int NV = 8;
   localparam int VEC [NV][5] = '{
      '{ 9,  0,  4, 0,  5},   // R7 mid duty
      '{ 9,  0,  0, 0,  1},   // R7 zero compare
      '{ 9,  0,  9, 0,  0},   // R7 compare equals period
      '{ 9,  0, 12, 0, 10},   // R7 compare beyond period
      '{15,  3, 10, 1,  7},   // R8 ordered edges
      '{15, 10,  3, 1,  9},   // R8 wrapped edges
      '{ 7,  2,  2, 1,  0},   // R8 equal edges
      '{20,  5, 19, 0, 20}    // R7 compare one below period
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int d);
      rd_addr = a;
      #1;
      d = int'(rd_data);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic measure(input int idx, input int cycles, output int hi);
      hi = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (pwm_out[idx]) hi++;
      end
   endtask

   task automatic setup(input int p, input int a, input int b, input int dbl);
      do_reset();
      wr(4'd8, p);
      wr(4'd9, a);
      wr(4'd10, b);
      wr(4'd3, 32'h2);
      wr(4'd4, (32'h1 << 10) | (dbl << 2));
      wr(4'd5, 32'h7);
      wr(4'd1, 32'h9);
      repeat (3 * (p + 1) + 4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v, v2, hi;
      do_reset();
      // R1 reset state
      rd(4'd0, v);  check("R1 flags", v, 0);
      rd(4'd1, v);  check("R1 ctrl", v, 0);
      rd(4'd2, v);  check("R1 count", v, 0);
      rd(4'd5, v);  check("R1 arm", v, 0);
      check("R1 outputs", int'(pwm_out), 0);
      check("R1 irq", int'(irq), 0);

      // vector table: duty of output 2
      for (int i = 0; i < NV; i++) begin
         setup(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
         measure(1, VEC[i][0] + 1, hi);
         check((VEC[i][3] != 0) ? "R8 double-edge duty" : "R7 single-edge duty", hi, VEC[i][4]);
      end

      // R5 and R6: shadow writes need arming
      setup(9, 0, 4, 0);
      rd(4'd5, v); check("R6 arm self-clears", v, 0);
      // R9: outputs 1 and 3 are disabled
      measure(0, 10, hi); check("R9 output 1 disabled", hi, 0);
      measure(2, 10, hi); check("R9 output 3 disabled", hi, 0);
      wr(4'd10, 32'd7);
      rd(4'd10, v); check("R5 shadow readback", v, 7);
      repeat (25) @(negedge clk);
      measure(1, 10, hi); check("R5 unarmed duty unchanged", hi, 5);
      wr(4'd5, 32'h4);
      repeat (34) @(negedge clk);
      measure(1, 10, hi); check("R6 armed duty updated", hi, 8);
      rd(4'd5, v); check("R6 arm cleared after copy", v, 0);
      // R10: modulator mode off
      wr(4'd1, 32'h1);
      measure(1, 20, hi); check("R10 mode off low", hi, 0);
      check("R10 all outputs low", int'(pwm_out), 0);

      // R2: free counting and hold at zero
      do_reset();
      wr(4'd1, 32'h1);
      rd(4'd2, v);
      repeat (5) @(negedge clk);
      rd(4'd2, v2);
      check("R2 advance per cycle", v2 - v, 5);
      wr(4'd1, 32'h3);
      repeat (3) @(negedge clk);
      rd(4'd2, v); check("R2 clear holds zero", v, 0);

      // R4: flags for channels 0 and 4, then write-1-to-clear
      do_reset();
      wr(4'd8, 32'd9);
      wr(4'd12, 32'd5);
      wr(4'd3, 32'h2 | 32'h1 | (32'h1 << 12));
      wr(4'd5, 32'h11);
      wr(4'd1, 32'h1);
      repeat (25) @(negedge clk);
      rd(4'd0, v); check("R4 flag positions", v, 32'h101);
      check("R4 irq high", int'(irq), 1);
      wr(4'd3, 32'h2);
      wr(4'd0, 32'h101);
      rd(4'd0, v); check("R4 flags cleared", v, 0);
      check("R4 irq low", int'(irq), 0);

      // R3: stop on channel 1 freezes count and clears run
      do_reset();
      wr(4'd8, 32'd50);
      wr(4'd9, 32'd3);
      wr(4'd3, 32'h2);
      wr(4'd5, 32'h3);
      wr(4'd1, 32'h1);
      repeat (3) @(negedge clk);
      wr(4'd3, 32'h2 | (32'h1 << 5));
      repeat (60) @(negedge clk);
      rd(4'd2, v); check("R3 stop freezes count", v, 3);
      rd(4'd1, v); check("R3 stop clears run", v, 0);
      repeat (5) @(negedge clk);
      rd(4'd2, v); check("R3 count stays frozen", v, 3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule